// File: doc/BRIEF.md
# Carry-Save Streaming Array Population Counter

This block counts the set bits across a stream of data words, such as a bitmap read out of an array. Words arrive one per cycle on a valid/ready handshake. A flag on the final word marks the end of the stream. No carries pass between bit positions during compression. Each bit column keeps its own four-bit counter made of bit-sliced half adders. Fifteen words therefore collapse into four plane words with weights 1, 2, 4 and 8.

When a group is complete, the block counts the four planes side by side with shift-and-mask reducers. It scales each count by its weight and adds the result into a running total. A group is complete when fifteen words have been taken or the flagged final word arrives. A short group needs no extra work, because the word slots it never filled count as zeros. Once the group holding the final word has been added, the block raises a one-cycle done pulse. The total then stays on the output until the next stream begins.

Top module: `csa_array_popcount`

## Requirements
- R1: After reset, `in_ready` is 1, `done_out` is 0 and `total_out` is 0.
- R2: A handshake occurs in a cycle where `in_valid` and `in_ready` are both 1. A handshake that does not close a group leaves `in_ready` at 1 in the next cycle.
- R3: A handshake closes a group when it carries `in_last`=1 or is the fifteenth word of the group. After it, `in_ready` is 0 for exactly two cycles and is 1 in the third cycle.
- R4: At the done pulse, `total_out` equals the sum of the set bits in every word accepted in the stream. This holds across several groups and for an all-ones stream.
- R5: A stream whose length is not a multiple of fifteen (for example 1, 14 or 16 words) gives the exact total, because the unfilled slots of its last group count as zero.
- R6: `done_out` is 1 for exactly one cycle. That cycle is the third cycle after the handshake carrying `in_last`=1.
- R7: `total_out` keeps its value after the done pulse. In the cycle after the first handshake of the next stream, it reads 0.
- R8: `in_data` and `in_last` have no effect unless a handshake occurs. While `in_ready` is 1 and `in_valid` is 0, `total_out` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word on `in_data` is offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | WORD_W | Word to be counted |
| in_last | input | 1 | Offered word is the final word of the stream |
| total_out | output | LEN_LOG2+clog2(WORD_W+1) | Running and final set-bit total |
| done_out | output | 1 | One-cycle pulse: total is final |

## Verification
A plane counter that overflows or drops a bit shows up as a wrong `total_out` at the done pulse, at most three cycles after the group closes. The reference model also tracks the partial total after every group, so the fault appears as soon as that group is added. A group counter that is off by one shifts the two-cycle low window on `in_ready`, and the per-cycle compare catches this on the first affected handshake. A missing stream-start clear, or a stale grouping flag, appears at the ports within one cycle of the next stream's first word, or as a misplaced done pulse.

// File: rtl/csa_pop_pkg.sv
package csa_pop_pkg;
  // number of weighted planes per bit column; a group fills 2^PLANES-1 words
  localparam int PLANES      = 4;
  localparam int GROUP_WORDS = (1 << PLANES) - 1;

  typedef enum logic [1:0] {
    PH_FILL  = 2'd0,
    PH_COUNT = 2'd1,
    PH_ADD   = 2'd2
  } phase_e;
endpackage

// File: rtl/csa_bit_slicer.sv
// Per-column counter built from bit-sliced half adders; no carry crosses columns.
module csa_bit_slicer #(
  parameter int WORD_W = 64,
  parameter int PLANES = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           add_en,
  input  logic                           clear,
  input  logic [WORD_W-1:0]              word,
  output logic [PLANES-1:0][WORD_W-1:0]  plane_o
);
  logic [PLANES-1:0][WORD_W-1:0] carry;

  assign carry[0] = word;

  genvar j;
  generate
    for (j = 0; j < PLANES; j++) begin : g_plane
      if (j < PLANES - 1) begin : g_carry
        assign carry[j+1] = plane_o[j] & carry[j];
      end
      always_ff @(posedge clk) begin
        if (rst || clear) begin
          plane_o[j] <= '0;
        end else if (add_en) begin
          plane_o[j] <= plane_o[j] ^ carry[j];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pop_shift_mask.sv
// Shift-and-mask reduction: pairs, then nibbles, then bytes, and so on.
module pop_shift_mask #(
  parameter int WORD_W = 64,
  localparam int CNT_W = $clog2(WORD_W + 1),
  localparam int LVL   = (WORD_W < 2) ? 1 : $clog2(WORD_W),
  localparam int PAD_W = 1 << LVL
) (
  input  logic [WORD_W-1:0] vec,
  output logic [CNT_W-1:0]  cnt
);
  logic [PAD_W-1:0] acc;
  logic [PAD_W-1:0] msk;

  always_comb begin
    acc = '0;
    acc[WORD_W-1:0] = vec;
    msk = '0;
    for (int k = 0; k < LVL; k++) begin
      for (int i = 0; i < PAD_W; i++) begin
        msk[i] = ((i >> k) & 1) == 0;
      end
      acc = (acc & msk) + ((acc >> (1 << k)) & msk);
    end
    cnt = CNT_W'(acc);
  end
endmodule

// File: rtl/pop_weight_sum.sv
// Scales each plane count by its binary weight and sums them.
module pop_weight_sum #(
  parameter int CNT_W  = 7,
  parameter int PLANES = 4,
  localparam int SUM_W = CNT_W + PLANES
) (
  input  logic [PLANES-1:0][CNT_W-1:0] cnt,
  output logic [SUM_W-1:0]             sum
);
  always_comb begin
    sum = '0;
    for (int j = 0; j < PLANES; j++) begin
      sum = sum + (SUM_W'(cnt[j]) << j);
    end
  end
endmodule

// File: rtl/csa_array_popcount.sv
module csa_array_popcount
  import csa_pop_pkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int LEN_LOG2 = 32,
  localparam int CNT_W   = $clog2(WORD_W + 1),
  localparam int TOTAL_W = LEN_LOG2 + CNT_W,
  localparam int SUM_W   = CNT_W + PLANES,
  localparam int FILL_W  = $clog2(GROUP_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WORD_W-1:0]  in_data,
  input  logic               in_last,
  output logic [TOTAL_W-1:0] total_out,
  output logic               done_out
);
  phase_e                        phase;
  logic [FILL_W-1:0]             fill_n;
  logic                          grp_last;
  logic                          clr_pend;
  logic [PLANES-1:0][WORD_W-1:0] planes;
  logic [PLANES-1:0][CNT_W-1:0]  pc_w;
  logic [PLANES-1:0][CNT_W-1:0]  pc_q;
  logic [SUM_W-1:0]              grp_sum;
  logic                          hs;
  logic                          closing;

  assign in_ready = (phase == PH_FILL);
  assign hs       = in_valid && in_ready;
  assign closing  = hs && (in_last || fill_n == FILL_W'(GROUP_WORDS - 1));

  csa_bit_slicer #(.WORD_W(WORD_W), .PLANES(PLANES)) slicer_i (
    .clk     (clk),
    .rst     (rst),
    .add_en  (hs),
    .clear   (phase == PH_COUNT),
    .word    (in_data),
    .plane_o (planes)
  );

  genvar p;
  generate
    for (p = 0; p < PLANES; p++) begin : g_cnt
      pop_shift_mask #(.WORD_W(WORD_W)) cnt_i (
        .vec (planes[p]),
        .cnt (pc_w[p])
      );
    end
  endgenerate

  pop_weight_sum #(.CNT_W(CNT_W), .PLANES(PLANES)) wsum_i (
    .cnt (pc_q),
    .sum (grp_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_FILL;
      fill_n    <= '0;
      grp_last  <= 1'b0;
      clr_pend  <= 1'b1;
      total_out <= '0;
      done_out  <= 1'b0;
      pc_q      <= '0;
    end else begin
      done_out <= 1'b0;
      case (phase)
        PH_FILL: begin
          if (hs) begin
            if (clr_pend) begin
              total_out <= '0;
              clr_pend  <= 1'b0;
            end
            if (closing) begin
              phase    <= PH_COUNT;
              grp_last <= in_last;
              fill_n   <= '0;
            end else begin
              fill_n <= fill_n + 1'b1;
            end
          end
        end
        PH_COUNT: begin
          pc_q  <= pc_w;
          phase <= PH_ADD;
        end
        PH_ADD: begin
          total_out <= total_out + TOTAL_W'(grp_sum);
          phase     <= PH_FILL;
          if (grp_last) begin
            done_out <= 1'b1;
            clr_pend <= 1'b1;
          end
        end
        default: phase <= PH_FILL;
      endcase
    end
  end
endmodule

// File: rtl/csa_pop_checker.sv
module csa_pop_checker #(
  parameter int TOTAL_W = 39
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_last,
  input logic [TOTAL_W-1:0] total_out,
  input logic               done_out
);
  logic [3:0] seen_n;
  logic       start_f;
  logic       hs;
  logic       closing;

  assign hs      = in_valid && in_ready;
  assign closing = hs && (in_last || seen_n == 4'd14);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_n  <= '0;
      start_f <= 1'b1;
    end else begin
      if (closing)  seen_n <= '0;
      else if (hs)  seen_n <= seen_n + 4'd1;
      if (hs)            start_f <= 1'b0;
      else if (done_out) start_f <= 1'b1;
    end
  end

  p_ready_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (hs && !closing) |=> in_ready);
  p_busy_first_r3: assert property (@(posedge clk) disable iff (rst)
    closing |=> !in_ready);
  p_busy_second_r3: assert property (@(posedge clk) disable iff (rst)
    closing |-> ##2 !in_ready);
  p_ready_back_r3: assert property (@(posedge clk) disable iff (rst)
    closing |-> ##3 in_ready);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done_out |=> !done_out);
  p_done_timing_r6: assert property (@(posedge clk) disable iff (rst)
    done_out |-> $past(in_valid && in_ready && in_last, 3));
  p_stream_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (hs && start_f) |=> (total_out == '0));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> $stable(total_out));
endmodule

bind csa_array_popcount csa_pop_checker #(.TOTAL_W(TOTAL_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .total_out (total_out),
  .done_out  (done_out)
);

// File: tb/csa_array_popcount_tb_top.sv
`timescale 1ns/1ps
module csa_array_popcount_tb_top;
  localparam int WORD_W  = 64;
  localparam int TOTAL_W = 32 + $clog2(WORD_W + 1);

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               vld = 1'b0;
  logic               rdy;
  logic [WORD_W-1:0]  data = '0;
  logic               last = 1'b0;
  logic [TOTAL_W-1:0] total;
  logic               done;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  csa_array_popcount #(.WORD_W(WORD_W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (vld),
    .in_ready  (rdy),
    .in_data   (data),
    .in_last   (last),
    .total_out (total),
    .done_out  (done)
  );

  // behavioural reference model, advanced at every rising edge
  int     m_ph;
  int     m_n;
  longint m_grp;
  longint m_total;
  bit     m_clr;
  bit     m_done;
  bit     m_glast;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_n = 0; m_grp = 0; m_total = 0;
      m_clr = 1; m_done = 0; m_glast = 0;
    end else begin
      m_done = 0;
      case (m_ph)
        0: if (vld) begin
             if (m_clr) begin m_total = 0; m_clr = 0; end
             m_grp += $countones(data);
             m_n++;
             if (m_n == 15 || last) begin m_ph = 1; m_glast = last; end
           end
        1: m_ph = 2;
        default: begin
          m_total += m_grp; m_grp = 0; m_n = 0; m_ph = 0;
          if (m_glast) begin m_done = 1; m_clr = 1; end
        end
      endcase
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  bit clr_due = 0;

  // one cycle: compare at the falling edge, before new inputs are driven
  task automatic step();
    @(negedge clk);
    chk("R2 R3 ready per cycle", longint'(rdy), longint'(m_ph == 0));
    chk("R6 done per cycle", longint'(done), longint'(m_done));
    chk("R4 total per cycle", longint'(total), m_total);
    if (clr_due) begin
      chk("R7 total cleared on stream start", longint'(total), 0);
      clr_due = 0;
    end
  endtask

  task automatic send_stream(int n, bit ones, bit gaps);
    longint exp_sum = 0;
    int     i = 0;
    bit     first = 1;
    int     guard = 0;
    while (i < n) begin
      step();
      if (!rdy) begin
        vld = 1; data = {$urandom, $urandom}; last = 1;   // ignored (R8)
      end else if (gaps && ($urandom % 3 == 0)) begin
        vld = 0; data = {$urandom, $urandom}; last = $urandom % 2;  // R8
      end else begin
        vld = 1;
        data = ones ? '1 : {$urandom, $urandom};
        last = (i == n - 1);
        exp_sum += $countones(data);
        i++;
        if (first) begin clr_due = 1; first = 0; end
      end
    end
    while (!done && guard < 20) begin
      step();
      guard++;
      if (!rdy) begin vld = 1; data = '1; last = 1; end
      else begin vld = 0; data = {$urandom, $urandom}; last = 0; end
    end
    if (n % 15 != 0)
      chk("R5 padded group total at done", longint'(total), exp_sum);
    else
      chk("R4 stream total at done", longint'(total), exp_sum);
    chk("R6 done seen", longint'(done), 1);
    // idle with stale inputs: total must hold (R7, R8)
    repeat (3) begin
      step();
      vld = 0; data = {$urandom, $urandom}; last = 1;
    end
    chk("R7 total held after done", longint'(total), exp_sum);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset ready", longint'(rdy), 1);
    chk("R1 reset done", longint'(done), 0);
    chk("R1 reset total", longint'(total), 0);
    send_stream(1, 0, 0);
    send_stream(14, 0, 0);
    send_stream(15, 0, 0);
    send_stream(16, 0, 1);
    send_stream(30, 0, 0);
    send_stream(30, 1, 0);
    send_stream(45, 1, 1);
    send_stream(23, 0, 1);
    for (int s = 0; s < 6; s++) send_stream(1 + ($urandom % 40), $urandom % 2, 1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule